// File: doc/BRIEF.md
# Scope Edge Trigger Detector

This block generates the acquisition trigger for a two-channel sampling front end. Two 8-bit sample streams arrive together under one valid strobe. One of them is chosen as the trigger source. The chosen stream goes through a four-sample moving average, and each new smoothed value is compared with a programmed level. When the smoothed signal crosses that level in the programmed direction, a one-cycle strobe is raised. That strobe is wired to the capture buffers of both channels, so they start together.

Control is static: an enable, an 8-bit level, a source select and an edge-direction bit. The level is in raw converter codes, with no offset or scale. The averaging history is flushed when enable drops or the source changes. After a flush the block waits for a fresh full window before it can fire, so a stale or partly filled window never produces a trigger.

Top module: `scope_edge_trigger`

## Requirements
- R1: While reset is held and after its release, `trig_o` is low and the averaging history is empty.
- R2: The smoothed value is floor((sum of the last 4 accepted samples of the selected channel) / 4). A sample is accepted only in a cycle with `sample_valid_i` high, and only if no flush (R6, R7) happens in that cycle.
- R3: With `dir_rise_i` = 1, an accepted sample fires when the previous smoothed value is below `trig_level_i` and the new one is greater than or equal to it. Equality with the level counts as reaching it.
- R4: With `dir_rise_i` = 0, an accepted sample fires when the previous smoothed value is greater than or equal to `trig_level_i` and the new one is below it.
- R5: `src_sel_i` = 0 routes channel A and `src_sel_i` = 1 routes channel B. The unselected channel has no effect on `trig_o`.
- R6: While `trig_en_i` is 0, `trig_o` stays low and the history, window count and smoothed value are cleared.
- R7: A cycle in which `src_sel_i` differs from its value in the previous cycle flushes the history as in R6. A sample presented in that cycle is discarded. After reset the previous selection is taken as 0.
- R8: No strobe fires unless both the previous and the new smoothed values come from full 4-sample windows. The earliest strobe is therefore on the 5th accepted sample after a flush or reset.
- R9: `trig_o` is high for exactly the one clock cycle that follows the rising clock edge that accepted the firing sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_valid_i | input | 1 | Both channel samples are valid this cycle |
| chan_a_i | input | 8 | Channel A sample, raw code |
| chan_b_i | input | 8 | Channel B sample, raw code |
| trig_en_i | input | 1 | Trigger enable |
| trig_level_i | input | 8 | Trigger level, raw code |
| src_sel_i | input | 1 | Trigger source: 0 = A, 1 = B |
| dir_rise_i | input | 1 | Edge: 1 = rising, 0 = falling |
| trig_o | output | 1 | One-cycle trigger strobe |

## Verification
The bench feeds a burst of high samples right after a flush. The partial averages then climb through the level: 50, 100, 150. A design that fires before the window is full triggers on the second sample. The bench also steps a sample so that the average lands exactly on the level, which catches a strict comparison. It inserts gaps in the valid strobe that carry junk data, which catches a filter that shifts on every clock. It changes the source and drops the enable in the middle of a stream, which catches history that is not flushed and leaks into the next decision. Finally it swings the unselected channel wildly and holds the signal above the level after a crossing, which exposes wrong routing and repeated strobes.

// File: rtl/scope_trig_pkg.sv
package scope_trig_pkg;
  localparam int unsigned SAMPLE_W = 8;
  localparam int unsigned AVG_LOG2 = 2;

  typedef enum logic {
    EDGE_FALL = 1'b0,
    EDGE_RISE = 1'b1
  } edge_dir_e;
endpackage

// File: rtl/trig_src_mux.sv
module trig_src_mux #(
  parameter int unsigned DW = scope_trig_pkg::SAMPLE_W
) (
  input  logic [DW-1:0] chan_a_i,
  input  logic [DW-1:0] chan_b_i,
  input  logic          sel_i,
  output logic [DW-1:0] sample_o
);
  always_comb sample_o = sel_i ? chan_b_i : chan_a_i;
endmodule

// File: rtl/trig_avg_filter.sv
module trig_avg_filter #(
  parameter int unsigned DW       = scope_trig_pkg::SAMPLE_W,
  parameter int unsigned WIN_LOG2 = scope_trig_pkg::AVG_LOG2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          upd_i,
  input  logic [DW-1:0] sample_i,
  output logic [DW-1:0] avg_q_o,
  output logic [DW-1:0] avg_next_o,
  output logic          full_o
);
  localparam int unsigned WIN   = 1 << WIN_LOG2;
  localparam int unsigned HIST  = WIN - 1;
  localparam int unsigned SUM_W = DW + WIN_LOG2;
  localparam int unsigned CNT_W = WIN_LOG2 + 1;

  logic [DW-1:0]    hist_q [HIST];
  logic [SUM_W-1:0] sum;
  logic [CNT_W-1:0] cnt_q;
  logic [DW-1:0]    avg_q;
  logic             full_q;

  // history shift register, newest at index 0
  for (genvar i = 0; i < HIST; i++) begin : g_hist
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     hist_q[i] <= '0;
      else if (clr_i)  hist_q[i] <= '0;
      else if (upd_i) begin
        if (i == 0) hist_q[i] <= sample_i;
        else        hist_q[i] <= hist_q[(i == 0) ? 0 : i-1];
      end
    end
  end

  always_comb begin
    sum = SUM_W'(sample_i);
    for (int i = 0; i < HIST; i++) sum = sum + SUM_W'(hist_q[i]);
    avg_next_o = DW'(sum >> WIN_LOG2);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      avg_q  <= '0;
      full_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q  <= '0;
      avg_q  <= '0;
      full_q <= 1'b0;
    end else if (upd_i) begin
      if (cnt_q != CNT_W'(WIN)) cnt_q <= cnt_q + 1'b1;
      avg_q  <= avg_next_o;
      full_q <= (cnt_q >= CNT_W'(HIST));
    end
  end

  assign avg_q_o = avg_q;
  assign full_o  = full_q;
endmodule

// File: rtl/trig_edge_cmp.sv
module trig_edge_cmp #(
  parameter int unsigned DW = scope_trig_pkg::SAMPLE_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          arm_i,
  input  logic          dir_rise_i,
  input  logic [DW-1:0] level_i,
  input  logic [DW-1:0] prev_i,
  input  logic [DW-1:0] cur_i,
  output logic          trig_o
);
  import scope_trig_pkg::*;

  logic      hit;
  logic      trig_q;
  edge_dir_e dir;

  always_comb begin
    dir = edge_dir_e'(dir_rise_i);
    if (dir == EDGE_RISE) hit = (prev_i <  level_i) && (cur_i >= level_i);
    else                  hit = (prev_i >= level_i) && (cur_i <  level_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) trig_q <= 1'b0;
    else         trig_q <= arm_i && hit;
  end

  assign trig_o = trig_q;
endmodule

// File: rtl/scope_edge_trigger.sv
module scope_edge_trigger #(
  parameter int unsigned DW       = scope_trig_pkg::SAMPLE_W,
  parameter int unsigned WIN_LOG2 = scope_trig_pkg::AVG_LOG2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sample_valid_i,
  input  logic [DW-1:0] chan_a_i,
  input  logic [DW-1:0] chan_b_i,
  input  logic          trig_en_i,
  input  logic [DW-1:0] trig_level_i,
  input  logic          src_sel_i,
  input  logic          dir_rise_i,
  output logic          trig_o
);
  logic          sel_q;
  logic          flush;
  logic          upd;
  logic [DW-1:0] src_sample;
  logic [DW-1:0] avg_q;
  logic [DW-1:0] avg_next;
  logic          full;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_q <= 1'b0;
    else         sel_q <= src_sel_i;
  end

  // flush on disable or any source change; a sample in that cycle is dropped
  assign flush = !trig_en_i || (src_sel_i != sel_q);
  assign upd   = sample_valid_i && !flush;

  trig_src_mux #(.DW(DW)) i_mux (
    .chan_a_i (chan_a_i),
    .chan_b_i (chan_b_i),
    .sel_i    (src_sel_i),
    .sample_o (src_sample)
  );

  trig_avg_filter #(.DW(DW), .WIN_LOG2(WIN_LOG2)) i_filt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (flush),
    .upd_i      (upd),
    .sample_i   (src_sample),
    .avg_q_o    (avg_q),
    .avg_next_o (avg_next),
    .full_o     (full)
  );

  trig_edge_cmp #(.DW(DW)) i_cmp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .arm_i      (upd && full),
    .dir_rise_i (dir_rise_i),
    .level_i    (trig_level_i),
    .prev_i     (avg_q),
    .cur_i      (avg_next),
    .trig_o     (trig_o)
  );
endmodule

// File: rtl/scope_edge_trigger_chk.sv
module scope_edge_trigger_chk #(
  parameter int unsigned DW = scope_trig_pkg::SAMPLE_W
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          sample_valid_i,
  input logic          trig_en_i,
  input logic [DW-1:0] trig_level_i,
  input logic          src_sel_i,
  input logic          dir_rise_i,
  input logic          trig_o
);
  logic       sel_seen_q;
  logic [2:0] acc_q;

  // independent count of accepted samples since the last flush
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_seen_q <= 1'b0;
      acc_q      <= '0;
    end else begin
      sel_seen_q <= src_sel_i;
      if (!trig_en_i || (src_sel_i != sel_seen_q)) acc_q <= '0;
      else if (sample_valid_i && acc_q != 3'd5)    acc_q <= acc_q + 3'd1;
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk_i) !rst_ni |-> !trig_o); // R1

  AST_NEEDS_ENABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trig_en_i |=> !trig_o); // R6

  AST_SEL_FLUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_sel_i != sel_seen_q) |=> !trig_o); // R7

  AST_FULL_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |-> (acc_q == 3'd5)); // R8

  AST_NEEDS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |-> $past(sample_valid_i)); // R9

  AST_SINGLE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o && $stable(trig_level_i) && $stable(dir_rise_i) |=> !trig_o); // R9
endmodule

bind scope_edge_trigger scope_edge_trigger_chk #(.DW(DW)) i_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .sample_valid_i (sample_valid_i),
  .trig_en_i      (trig_en_i),
  .trig_level_i   (trig_level_i),
  .src_sel_i      (src_sel_i),
  .dir_rise_i     (dir_rise_i),
  .trig_o         (trig_o)
);

// File: tb/test_scope_edge_trigger.sv
`timescale 1ns/1ps
module test_scope_edge_trigger;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sample_valid_i = 1'b0;
  logic [7:0] chan_a_i = '0;
  logic [7:0] chan_b_i = '0;
  logic       trig_en_i = 1'b0;
  logic [7:0] trig_level_i = '0;
  logic       src_sel_i = 1'b0;
  logic       dir_rise_i = 1'b1;
  logic       trig_o;

  always #4 clk_i = ~clk_i;

  scope_edge_trigger i_scope_edge_trigger (.*);

  typedef struct { bit exp; string tag; } exp_t;
  exp_t q[$];

  int  checks = 0;
  int  fails  = 0;
  int  strobes_exp = 0;
  bit  done = 0;

  // reference state built from the requirements
  logic [7:0] h_m [3];
  int         cnt_m = 0;
  bit         full_m = 0;
  logic [7:0] avg_m = '0;
  bit         sel_m = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit crossed(logic [7:0] p, logic [7:0] c);
    if (dir_rise_i) return (p < trig_level_i) && (c >= trig_level_i);
    return (p >= trig_level_i) && (c < trig_level_i);
  endfunction

  task automatic model_clear();
    for (int i = 0; i < 3; i++) h_m[i] = '0;
    cnt_m = 0; full_m = 0; avg_m = '0;
  endtask

  // driver: applies one cycle of stimulus and queues the expected strobe
  task automatic step(logic [7:0] a, logic [7:0] b, bit v, string tag);
    bit         e;
    bit         flush;
    logic [7:0] s;
    logic [9:0] sum;
    @(negedge clk_i);
    chan_a_i = a; chan_b_i = b; sample_valid_i = v;
    e = 0;
    flush = !trig_en_i || (src_sel_i != sel_m);
    sel_m = src_sel_i;
    if (flush) model_clear();
    else if (v) begin
      s   = src_sel_i ? b : a;
      sum = 10'(s) + 10'(h_m[0]) + 10'(h_m[1]) + 10'(h_m[2]);
      e   = full_m && crossed(avg_m, sum[9:2]);
      full_m = (cnt_m >= 3);
      if (cnt_m < 4) cnt_m++;
      h_m[2] = h_m[1]; h_m[1] = h_m[0]; h_m[0] = s;
      avg_m = sum[9:2];
    end
    if (e) strobes_exp++;
    q.push_back('{exp: e, tag: tag});
  endtask

  // monitor: compares one queued item per cycle, away from the edge
  initial begin
    forever begin
      @(posedge clk_i);
      #2;
      if (q.size() > 0) begin
        exp_t it;
        it = q.pop_front();
        chk(trig_o === it.exp, it.tag, int'(trig_o), int'(it.exp));
      end
    end
  end

  task automatic drain();
    repeat (3) @(posedge clk_i);
    #3;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    fails++; checks++;
    $display("FAIL watchdog act=0 exp=1");
    finish_run();
  end

  initial begin
    int n0;
    model_clear();
    repeat (3) @(negedge clk_i);
    chk(trig_o === 1'b0, "R1 in reset", int'(trig_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(trig_o === 1'b0, "R1 after reset", int'(trig_o), 0);

    // rising ramp on A, B held high
    trig_en_i = 1; src_sel_i = 0; dir_rise_i = 1; trig_level_i = 8'd100;
    n0 = strobes_exp;
    for (int i = 0; i < 6; i++) step(8'd60, 8'd250, 1, "R3 rise baseline");
    for (int i = 0; i < 8; i++) step(8'(80 + 20*i), 8'd250, 1, "R3 rise ramp");
    for (int i = 0; i < 6; i++) step(8'd200, 8'd0, 1, "R9 hold above");
    drain();
    chk(strobes_exp - n0 == 1, "R3 one strobe expected", strobes_exp - n0, 1);

    // exact-level boundary: avg (96*3+112)/4 = 100
    for (int i = 0; i < 6; i++) step(8'd96, 8'd0, 1, "R3 level minus");
    step(8'd112, 8'd0, 1, "R3 equal level fires");
    step(8'd112, 8'd0, 1, "R9 no repeat");
    drain();

    // falling on B; source change flushes
    src_sel_i = 1; dir_rise_i = 0; trig_level_i = 8'd90;
    n0 = strobes_exp;
    step(8'd0, 8'd150, 1, "R7 change cycle dropped");
    for (int i = 0; i < 5; i++) step(8'd0, 8'd150, 1, "R4 fall baseline");
    for (int i = 0; i < 6; i++) step(8'd255, 8'd40, 1, "R4 fall crossing");
    drain();
    chk(strobes_exp - n0 == 1, "R4 one strobe expected", strobes_exp - n0, 1);

    // unselected channel swings, selected steady
    src_sel_i = 0; dir_rise_i = 1; trig_level_i = 8'd100;
    for (int i = 0; i < 12; i++) step(8'd60, (i % 2) ? 8'd255 : 8'd0, 1, "R5 other channel ignored");
    for (int i = 0; i < 6; i++) step(8'd60, 8'd0, 1, "R5 settle");
    // A above, B stays low: switching to B (low) must not fire from A history
    for (int i = 0; i < 6; i++) step(8'd220, 8'd10, 1, "R5 A high");
    src_sel_i = 1;
    for (int i = 0; i < 6; i++) step(8'd220, 8'd10, 1, "R7 switch to B low");
    drain();

    // partial window after flush must not fire: avgs 50,100,150,200
    src_sel_i = 0;
    n0 = strobes_exp;
    step(8'd0, 8'd0, 0, "R7 switch back");
    for (int i = 0; i < 6; i++) step(8'd200, 8'd0, 1, "R8 no early strobe");
    drain();
    chk(strobes_exp - n0 == 0, "R8 no strobe expected", strobes_exp - n0, 0);

    // valid gaps carry junk that must not enter the window
    for (int i = 0; i < 5; i++) begin
      step(8'd60, 8'd0, 1, "R2 low with gaps");
      step(8'd255, 8'd255, 0, "R2 gap junk");
    end
    step(8'd60, 8'd0, 1, "R2 low");
    step(8'd140, 8'd0, 0, "R2 gap");
    step(8'd140, 8'd0, 1, "R2 avg 80");
    step(8'd140, 8'd0, 1, "R2 avg 100 fires");
    step(8'd140, 8'd0, 1, "R2 avg 120");
    drain();

    // disable mid-stream, then re-enable: history must be empty
    for (int i = 0; i < 5; i++) step(8'd60, 8'd0, 1, "R6 before disable");
    trig_en_i = 0;
    for (int i = 0; i < 6; i++) step(8'd200, 8'd0, 1, "R6 disabled crossing");
    trig_en_i = 1;
    for (int i = 0; i < 4; i++) step(8'd120, 8'd0, 1, "R6 refill");
    step(8'd120, 8'd0, 1, "R6 refilled no cross");
    for (int i = 0; i < 5; i++) step(8'd50, 8'd0, 1, "R6 drop");
    for (int i = 0; i < 4; i++) step(8'd180, 8'd0, 1, "R6 rise after refill");
    drain();

    finish_run();
  end
endmodule